// File: doc/BRIEF.md
# Retention-Binned Refresh Scheduler

This block decides, slot by slot, whether a DRAM row group gets a refresh command. An external strobe (`tick`) arrives once per average refresh interval, which is nominally 7.8 us. Each strobe opens the slot of the row group under a rotating pointer. One full pass of the pointer over all groups is one epoch, and one epoch equals the 64 ms base retention window. A 2-bit epoch count lets groups with better retention be refreshed only every second or every fourth epoch. That gives periods of 128 ms and 256 ms.

A group's period comes from two Bloom filters that software programs one bit at a time. A hit in the fast filter gives 64 ms. A hit in the medium filter gives 128 ms. A group that hits neither filter gets 256 ms. A read or write of a group refreshes its rows as a side effect, so the block watches the access stream. It drops the next scheduled refresh of any group touched since that group's previous slot.

Each issued refresh holds a busy flag for a programmable number of cycles, so that normal traffic can stay off the memory while the refresh runs.

Top module: `refresh_binner`

## Requirements
- R1: After a synchronous reset, `ref_valid` and `busy` are 0 and `ref_group` is 0. The pointer and epoch both start at 0. Both filters are cleared and no group is marked as recently accessed.
- R2: A `tick` sampled at a clock edge serves the group at the pointer, and the pointer then advances by one, modulo the number of groups. If that slot issues a refresh, `ref_valid` is high for exactly the one cycle after that edge, and `ref_group` carries the served group. `ref_valid` is never high without a tick on the previous edge.
- R3: Group g hits filter k only when both of its bits are set: bit (29*g+7) mod 256 and bit (151*g+83) mod 256. A group with just one of the two bits set does not hit.
- R4: The period comes from the lowest-numbered filter that the group hits. A hit in filter 0 makes the group due in every epoch. A hit in filter 1 (and none in filter 0) makes it due when the epoch is even. A group that hits no filter is due only in epoch 0.
- R5: The epoch is a 2-bit counter. It increments (wrapping 3 to 0) on the tick that serves the last group, and at no other time.
- R6: An access (`acc_valid`) marks its group as recently accessed. A due slot whose group is marked issues nothing. Every slot clears its group's mark. If an access to the served group arrives in the same cycle as the tick, the mark is set again.
- R7: An issued refresh makes `busy` high for exactly `busy_len` cycles, starting with the `ref_valid` cycle. A value of 0 gives no busy cycles. A slot that is skipped or not due leaves `busy` low.
- R8: A programming write (`prog_we`) sets or clears (`prog_bit`) bit `prog_idx` of the filter chosen by `prog_sel` (0 = 64 ms filter, 1 = 128 ms filter). It changes no other bit, and it affects every later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Refresh-interval strobe; one slot per strobe |
| acc_valid | input | 1 | A row access occurred this cycle |
| acc_group | input | GROUP_W | Row group of the access |
| prog_we | input | 1 | Filter bit write strobe |
| prog_sel | input | 1 | Filter select (0 fast, 1 medium) |
| prog_idx | input | IDX_W | Filter bit index |
| prog_bit | input | 1 | Value written to the filter bit |
| busy_len | input | BUSY_W | Busy cycles per issued refresh |
| ref_valid | output | 1 | Refresh command pulse |
| ref_group | output | GROUP_W | Row group being refreshed |
| busy | output | 1 | Memory unavailable |

## Verification
The bench sweeps every slot of twelve epochs and covers all four epoch values under each bin. It predicts each slot from its own model of the filter bits and the hash arithmetic. A scheduler with swapped or inverted epoch conditions would refresh 128 ms and 256 ms groups in the wrong epochs. A design that lets a single hashed bit count as a hit would wrongly move the half-programmed group into the fast bin. The bench includes an access that arrives in the same cycle as its group's tick. A design where the clear beats the set would then refresh a group that was just touched one epoch later. Busy lengths of 0, 3 and 7 expose off-by-one errors in the busy window, and they catch a busy raised by a skipped slot.

// File: rtl/refbin_pkg.sv
package refbin_pkg;
  // First index into a filter for a row group (taken modulo the filter size).
  function automatic logic [31:0] hash_a(input logic [31:0] g);
    return g * 32'd29 + 32'd7;
  endfunction
  // Second, independent index.
  function automatic logic [31:0] hash_b(input logic [31:0] g);
    return g * 32'd151 + 32'd83;
  endfunction
endpackage

// File: rtl/refbin_filter.sv
module refbin_filter #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] look_a,
  input  logic [IDX_W-1:0] look_b,
  output logic             hit
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else if (wr_en) bits_q[wr_idx] <= wr_bit;
  end

  assign hit = bits_q[look_a] & bits_q[look_b];
endmodule

// File: rtl/refbin_recent.sv
module refbin_recent #(
  parameter int GROUP_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [GROUP_W-1:0] acc_group,
  input  logic               slot_en,
  input  logic [GROUP_W-1:0] slot_group,
  output logic               was_recent,
  output logic [(1<<GROUP_W)-1:0] mark_vec
);
  localparam int GROUPS = 1 << GROUP_W;
  logic [GROUPS-1:0] mark_q;

  // The access update comes last, so it wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) mark_q <= '0;
    else begin
      if (slot_en)   mark_q[slot_group] <= 1'b0;
      if (acc_valid) mark_q[acc_group]  <= 1'b1;
    end
  end

  assign was_recent = mark_q[slot_group];
  assign mark_vec   = mark_q;
endmodule

// File: rtl/refbin_slots.sv
module refbin_slots #(
  parameter int GROUP_W = 4,
  parameter int EPOCH_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [GROUP_W-1:0] ptr_q,
  output logic [EPOCH_W-1:0] epoch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      epoch_q <= '0;
    end else if (tick) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == {GROUP_W{1'b1}}) epoch_q <= epoch_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_binner.sv
module refresh_binner #(
  parameter int GROUP_W = 4,
  parameter int IDX_W   = 8,
  parameter int FILTERS = 2,
  parameter int BUSY_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               acc_valid,
  input  logic [GROUP_W-1:0] acc_group,
  input  logic               prog_we,
  input  logic [((FILTERS > 1) ? $clog2(FILTERS) : 1)-1:0] prog_sel,
  input  logic [IDX_W-1:0]   prog_idx,
  input  logic               prog_bit,
  input  logic [BUSY_W-1:0]  busy_len,
  output logic               ref_valid,
  output logic [GROUP_W-1:0] ref_group,
  output logic               busy
);
  import refbin_pkg::*;

  localparam int SEL_W   = (FILTERS > 1) ? $clog2(FILTERS) : 1;
  localparam int EPOCH_W = FILTERS;
  localparam int GROUPS  = 1 << GROUP_W;

  logic [GROUP_W-1:0] ptr_q;
  logic [EPOCH_W-1:0] epoch_q;
  logic [FILTERS-1:0] hits;
  logic               was_recent;
  logic [GROUPS-1:0]  mark_vec;
  logic [31:0]        ha_full, hb_full;
  logic [IDX_W-1:0]   idx_a, idx_b;
  logic               due, issue;
  logic [BUSY_W-1:0]  busy_cnt;
  logic               ref_valid_q;
  logic [GROUP_W-1:0] ref_group_q;

  refbin_slots #(.GROUP_W(GROUP_W), .EPOCH_W(EPOCH_W)) u_slots (
    .clk(clk), .rst(rst), .tick(tick), .ptr_q(ptr_q), .epoch_q(epoch_q)
  );

  assign ha_full = hash_a(32'(ptr_q));
  assign hb_full = hash_b(32'(ptr_q));
  assign idx_a   = ha_full[IDX_W-1:0];
  assign idx_b   = hb_full[IDX_W-1:0];

  for (genvar k = 0; k < FILTERS; k++) begin : g_filter
    refbin_filter #(.IDX_W(IDX_W)) u_filter (
      .clk(clk), .rst(rst),
      .wr_en(prog_we && (prog_sel == SEL_W'(k))),
      .wr_idx(prog_idx), .wr_bit(prog_bit),
      .look_a(idx_a), .look_b(idx_b), .hit(hits[k])
    );
  end

  refbin_recent #(.GROUP_W(GROUP_W)) u_recent (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_group(acc_group),
    .slot_en(tick), .slot_group(ptr_q), .was_recent(was_recent),
    .mark_vec(mark_vec)
  );

  // Lowest-numbered hit wins; filter k means a period of 2^k epochs.
  always_comb begin
    logic found;
    logic [EPOCH_W-1:0] mask;
    found = 1'b0;
    due   = (epoch_q == '0);
    for (int k = 0; k < FILTERS; k++) begin
      mask = EPOCH_W'((32'd1 << k) - 32'd1);
      if (!found && hits[k]) begin
        found = 1'b1;
        due   = ((epoch_q & mask) == '0);
      end
    end
  end

  assign issue = tick && due && !was_recent;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_valid_q <= 1'b0;
      ref_group_q <= '0;
      busy_cnt    <= '0;
    end else begin
      ref_valid_q <= issue;
      if (issue) ref_group_q <= ptr_q;
      if (issue) busy_cnt <= busy_len;
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign ref_valid = ref_valid_q;
  assign ref_group = ref_group_q;
  assign busy      = (busy_cnt != '0);
endmodule

// File: rtl/refbin_checker.sv
module refbin_checker #(
  parameter int GROUP_W = 4,
  parameter int FILTERS = 2,
  parameter int BUSY_W  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     ref_valid,
  input logic                     busy,
  input logic [BUSY_W-1:0]        busy_len,
  input logic [GROUP_W-1:0]       ptr,
  input logic [FILTERS-1:0]       epoch,
  input logic [(1<<GROUP_W)-1:0]  marks
);
  p_issue_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    ref_valid |-> $past(tick));

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    $past(tick) |-> ptr == GROUP_W'($past(ptr) + 1'b1));

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(ptr));

  p_epoch_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && $past(ptr) == {GROUP_W{1'b1}}) |-> epoch == FILTERS'($past(epoch) + 1'b1));

  p_epoch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !($past(tick) && $past(ptr) == {GROUP_W{1'b1}}) |-> $stable(epoch));

  p_skip_marked_r6: assert property (@(posedge clk) disable iff (rst)
    ref_valid |-> !$past(marks[ptr]));

  p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ref_valid);

  p_busy_on_issue_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && $past(busy_len) != '0) |-> busy);
endmodule

bind refresh_binner refbin_checker #(.GROUP_W(GROUP_W), .FILTERS(FILTERS), .BUSY_W(BUSY_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ref_valid(ref_valid), .busy(busy),
  .busy_len(busy_len), .ptr(ptr_q), .epoch(epoch_q), .marks(mark_vec)
);

// File: tb/refresh_binner_test.sv
module refresh_binner_test;
  localparam int GROUPS = 16;
  localparam int GAP    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       acc_valid = 1'b0;
  logic [3:0] acc_group = '0;
  logic       prog_we = 1'b0;
  logic [0:0] prog_sel = '0;
  logic [7:0] prog_idx = '0;
  logic       prog_bit = 1'b0;
  logic [7:0] busy_len = 8'd3;
  logic       ref_valid;
  logic [3:0] ref_group;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit fbits [2][256];
  bit mark [GROUPS];
  int ptr = 0;
  int epoch = 0;

  always #4 clk = ~clk;

  refresh_binner uut (
    .clk(clk), .rst(rst), .tick(tick), .acc_valid(acc_valid), .acc_group(acc_group),
    .prog_we(prog_we), .prog_sel(prog_sel), .prog_idx(prog_idx), .prog_bit(prog_bit),
    .busy_len(busy_len), .ref_valid(ref_valid), .ref_group(ref_group), .busy(busy)
  );

  function automatic int ha(int g); return (g * 29 + 7) % 256; endfunction
  function automatic int hb(int g); return (g * 151 + 83) % 256; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (ptr %0d epoch %0d)", req, act, exp, ptr, epoch);
    end
  endtask

  task automatic prog(int sel, int idx, bit val);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = 1'(sel); prog_idx = 8'(idx); prog_bit = val;
    @(negedge clk);
    prog_we = 1'b0;
    fbits[sel][idx] = val;
  endtask

  task automatic access(int g);
    @(negedge clk);
    acc_valid = 1'b1; acc_group = 4'(g);
    @(negedge clk);
    acc_valid = 1'b0;
    mark[g] = 1'b1;
  endtask

  function automatic bit model_due(int g, int ep);
    bit h0, h1;
    h0 = fbits[0][ha(g)] && fbits[0][hb(g)];
    h1 = fbits[1][ha(g)] && fbits[1][hb(g)];
    if (h0) return 1'b1;
    if (h1) return (ep % 2) == 0;
    return ep == 0;
  endfunction

  // One slot: tick (optionally with an access to the served group), then GAP sample cycles.
  task automatic slot(bit same_acc);
    bit exp_issue;
    int served;
    @(negedge clk);
    tick = 1'b1;
    acc_valid = same_acc; acc_group = 4'(ptr);
    served = ptr;
    exp_issue = model_due(ptr, epoch) && !mark[ptr];
    mark[ptr] = 1'b0;
    if (same_acc) mark[ptr] = 1'b1;
    @(negedge clk);
    tick = 1'b0; acc_valid = 1'b0;
    chk("R4/R6 ref_valid", int'(ref_valid), int'(exp_issue));
    if (exp_issue) chk("R2 ref_group", int'(ref_group), served);
    chk("R7 busy", int'(busy), int'(exp_issue && busy_len > 0));
    for (int k = 1; k < GAP; k++) begin
      @(negedge clk);
      chk("R2 single pulse", int'(ref_valid), 0);
      chk("R7 busy window", int'(busy), int'(exp_issue && k < int'(busy_len)));
    end
    if (ptr == GROUPS - 1) epoch = (epoch + 1) % 4;
    ptr = (ptr + 1) % GROUPS;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ref_valid", int'(ref_valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ref_group", int'(ref_group), 0);

    // R4/R5: empty filters -> all due in epoch 0, none in epoch 1
    for (int t = 0; t < 2 * GROUPS; t++) slot(1'b0);

    // R3/R8: program bins; group 5 in both filters; group 7 half-programmed
    prog(0, ha(2), 1'b1); prog(0, hb(2), 1'b1);
    prog(0, ha(5), 1'b1); prog(0, hb(5), 1'b1);
    prog(0, ha(7), 1'b1);
    prog(1, ha(5), 1'b1); prog(1, hb(5), 1'b1);
    prog(1, ha(9), 1'b1); prog(1, hb(9), 1'b1);
    prog(1, ha(12), 1'b1); prog(1, hb(12), 1'b1);

    // R4/R5/R6/R7: six epochs with accesses and varying busy lengths
    for (int t = 0; t < 6 * GROUPS; t++) begin
      if (t % GROUPS == 0) busy_len = 8'((t / GROUPS) % 3 == 0 ? 3 : ((t / GROUPS) % 3 == 1 ? 0 : 7));
      if (t % 5 == 1) access((t * 7 + 3) % GROUPS);
      slot(t % 7 == 3);
    end

    // R8: clear one bit of group 2 in the fast filter
    prog(0, ha(2), 1'b0);
    busy_len = 8'd2;
    for (int t = 0; t < 4 * GROUPS; t++) begin
      if (t % 6 == 2) access((t * 5 + 1) % GROUPS);
      slot(t % 9 == 4);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule